// File: doc/BRIEF.md
# Disk Command Busy and Interrupt Controller

This block sits between the host bus and the command executors of a floppy disk controller. It keeps the busy flag and the interrupt request line. It decodes the command class from each host command write and decides whether the write is accepted. An accepted command is handed on as a one-cycle strobe carrying its class. Completion pulses from the executors end a command and raise the interrupt. A status read from the host lowers the interrupt again.

The force-interrupt class is accepted at any time. It aborts a running command, and it can arm interrupt conditions on the drive's ready and index inputs. Read and write commands are refused when the drive is not ready. Write commands are also refused when the media is write-protected. Each refusal raises the interrupt at once. The ready and index inputs are asynchronous and are resynchronised inside the block.

Top module: `cmd_irq_ctrl`

## Requirements
- R1: After reset, busy, intrq, acceptStb, abortReq and wpStat are all 0.
- R2: Command bits 7:4 set the class on acceptType. 0xxx is class I (code 0), 10xx is class II (code 1), 1100, 1110 and 1111 are class III (code 2), and 1101 is force interrupt (code 3). The cycle after an accepted class I-III write, acceptStb is high for one cycle and busy is 1.
- R3: A doneStb while busy clears busy and raises intrq in the following cycle. A doneStb while idle has no effect.
- R4: intrq is cleared by a statRd pulse or by an accepted command write. If a statRd arrives in the same cycle as an interrupt-setting event, intrq stays set.
- R5: While busy, a command write of class I-III is ignored: there is no strobe, busy stays 1 and intrq is unchanged.
- R6: A force-interrupt write is accepted even while busy. It clears busy, gives acceptStb with code 3, and gives a one-cycle abortReq if a command was running. When its condition bits 3:0 are all zero, intrq stays low.
- R7: Condition bit 0 arms an interrupt on a not-ready-to-ready edge of drvReady. Condition bit 1 arms one on a ready-to-not-ready edge. intrq rises within 5 cycles of the edge. An edge that is not armed raises nothing.
- R8: Condition bit 2 arms an interrupt on a rising edge of idxPulse. An accepted class I-III command disarms all conditions.
- R9: Condition bit 3 raises intrq in the next cycle and holds it high, through status reads and command writes, until reset.
- R10: A class II or III write while the synchronised drvReady is low is not started. busy stays 0, there is no strobe, and intrq rises the next cycle. Class I commands start regardless of ready.
- R11: A write command (bits 7:4 = 101x or 1111) with wrProtN low is not started. intrq and wpStat rise the next cycle. wpStat clears on the next accepted command write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWr | input | 1 | Host command-register write strobe |
| cmdData | input | 8 | Host command byte |
| statRd | input | 1 | Host status-register read strobe |
| doneStb | input | 1 | Completion pulse from the command executors |
| drvReady | input | 1 | Drive ready, asynchronous, high = ready |
| idxPulse | input | 1 | Index pulse, asynchronous |
| wrProtN | input | 1 | Write protect, low = protected |
| busy | output | 1 | Command in progress |
| intrq | output | 1 | Interrupt request |
| wpStat | output | 1 | Last write was refused for write protect |
| acceptStb | output | 1 | One-cycle strobe for an accepted command |
| acceptType | output | 2 | Class of the accepted command |
| abortReq | output | 1 | One-cycle abort request to the executors |

## Verification
A wrong busy flag shows up one cycle after the next command write. A command is then either dropped or started while another one runs. A lost or stuck armed condition appears at intrq within five cycles of the next ready or index edge. A wrong hold on the immediate interrupt appears at the first status read after it. Each scenario samples the ports at the first cycle where the result must be visible. It also checks the cycle after, so that strobes that last too long are caught.

// File: rtl/cmd_irq_pkg.sv
package cmd_irq_pkg;
  typedef enum logic [1:0] {
    CT_I   = 2'd0,
    CT_II  = 2'd1,
    CT_III = 2'd2,
    CT_IV  = 2'd3
  } cmdType_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCond;
    logic clearCond;
    logic setWp;
    logic clearWp;
  } dpStb_t;
endpackage

// File: rtl/cmd_irq_sync.sv
module cmd_irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sh;
  logic prev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sh   <= '0;
      prev <= 1'b0;
    end else begin
      sh   <= {sh[STAGES-2:0], din};
      prev <= sh[STAGES-1];
    end
  end

  assign lvl  = sh[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/cmd_irq_dp.sv
module cmd_irq_dp
  import cmd_irq_pkg::*;
#(
  parameter int CMD_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int COND_W      = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CMD_W-1:0] cmdData,
  input  logic             drvReady,
  input  logic             idxPulse,
  input  dpStb_t           stb,
  output cmdType_e         cmdType,
  output logic             isWrite,
  output logic             readyNow,
  output logic             evtHit,
  output logic             wpStat
);
  localparam int NIB_LO = CMD_W - 4;
  localparam int N_IN   = 2;

  logic [3:0]        nib;
  logic [N_IN-1:0]   asyncIn, lvl, rise, fall;
  logic [COND_W-1:0] cond;

  assign nib     = cmdData[CMD_W-1:NIB_LO];
  assign asyncIn = {idxPulse, drvReady};

  for (genvar gi = 0; gi < N_IN; gi++) begin : g_sync
    cmd_irq_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk (clk),
      .rstN(rstN),
      .din (asyncIn[gi]),
      .lvl (lvl[gi]),
      .rise(rise[gi]),
      .fall(fall[gi])
    );
  end

  always_comb begin
    if (!nib[3])                 cmdType = CT_I;
    else if (!nib[2])            cmdType = CT_II;
    else if (nib == 4'b1101)     cmdType = CT_IV;
    else                         cmdType = CT_III;
  end

  assign isWrite  = (nib[3:1] == 3'b101) || (nib == 4'b1111);
  assign readyNow = lvl[0];
  assign evtHit   = (cond[0] & rise[0]) | (cond[1] & fall[0]) | (cond[2] & rise[1]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cond   <= '0;
      wpStat <= 1'b0;
    end else begin
      if (stb.loadCond)       cond <= cmdData[COND_W-1:0];
      else if (stb.clearCond) cond <= '0;
      if (stb.setWp)          wpStat <= 1'b1;
      else if (stb.clearWp)   wpStat <= 1'b0;
    end
  end
endmodule

// File: rtl/cmd_irq_ctl.sv
module cmd_irq_ctl
  import cmd_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdWr,
  input  logic       statRd,
  input  logic       doneStb,
  input  logic       wrProtN,
  input  logic       immBit,
  input  cmdType_e   cmdType,
  input  logic       isWrite,
  input  logic       readyNow,
  input  logic       evtHit,
  output dpStb_t     stb,
  output logic       busy,
  output logic       intrq,
  output logic       acceptStb,
  output logic [1:0] acceptType,
  output logic       abortReq
);
  logic wrTake, isFi, needRdy, refuseRdy, refuseWp, start, doneEvt;
  logic setIrq, clrIrq, immHold;

  always_comb begin
    wrTake    = cmdWr && (!busy || cmdType == CT_IV);
    isFi      = wrTake && cmdType == CT_IV;
    needRdy   = cmdType == CT_II || cmdType == CT_III;
    refuseRdy = wrTake && needRdy && !readyNow;
    refuseWp  = wrTake && needRdy && readyNow && isWrite && !wrProtN;
    start     = wrTake && !isFi && !refuseRdy && !refuseWp;
    doneEvt   = doneStb && busy && !isFi;
    setIrq    = doneEvt || refuseRdy || refuseWp || evtHit || (isFi && immBit);
    clrIrq    = statRd || wrTake;
    stb.loadCond  = isFi;
    stb.clearCond = wrTake && !isFi;
    stb.setWp     = refuseWp;
    stb.clearWp   = wrTake && !refuseWp;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy       <= 1'b0;
      intrq      <= 1'b0;
      immHold    <= 1'b0;
      acceptStb  <= 1'b0;
      acceptType <= 2'd0;
      abortReq   <= 1'b0;
    end else begin
      if (start)                busy <= 1'b1;
      else if (isFi || doneEvt) busy <= 1'b0;
      if (isFi && immBit) immHold <= 1'b1;
      intrq      <= setIrq || immHold || (intrq && !clrIrq);
      acceptStb  <= start || isFi;
      acceptType <= cmdType;
      abortReq   <= isFi && busy;
    end
  end
endmodule

// File: rtl/cmd_irq_ctrl.sv
module cmd_irq_ctrl
  import cmd_irq_pkg::*;
#(
  parameter int CMD_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWr,
  input  logic [CMD_W-1:0] cmdData,
  input  logic             statRd,
  input  logic             doneStb,
  input  logic             drvReady,
  input  logic             idxPulse,
  input  logic             wrProtN,
  output logic             busy,
  output logic             intrq,
  output logic             wpStat,
  output logic             acceptStb,
  output logic [1:0]       acceptType,
  output logic             abortReq
);
  dpStb_t   stb;
  cmdType_e cmdType;
  logic     isWrite, readyNow, evtHit;

  cmd_irq_dp #(.CMD_W(CMD_W), .SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk(clk), .rstN(rstN), .cmdData(cmdData), .drvReady(drvReady),
    .idxPulse(idxPulse), .stb(stb), .cmdType(cmdType), .isWrite(isWrite),
    .readyNow(readyNow), .evtHit(evtHit), .wpStat(wpStat)
  );

  cmd_irq_ctl i_ctl (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .statRd(statRd),
    .doneStb(doneStb), .wrProtN(wrProtN), .immBit(cmdData[3]),
    .cmdType(cmdType), .isWrite(isWrite), .readyNow(readyNow),
    .evtHit(evtHit), .stb(stb), .busy(busy), .intrq(intrq),
    .acceptStb(acceptStb), .acceptType(acceptType), .abortReq(abortReq)
  );
endmodule

// File: rtl/cmd_irq_chk.sv
module cmd_irq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cmdWr,
  input logic [7:0] cmdData,
  input logic       doneStb,
  input logic       busy,
  input logic       intrq,
  input logic       acceptStb,
  input logic [1:0] acceptType,
  input logic       abortReq
);
  logic fiWr;
  assign fiWr = cmdWr && cmdData[7:4] == 4'b1101;

  AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    busy && doneStb && !fiWr |=> !busy && intrq); // R3 R4

  AST_FI_ABORTS: assert property (@(posedge clk) disable iff (!rstN)
    busy && fiWr |=> !busy && abortReq && acceptStb && acceptType == 2'd3); // R6

  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rstN)
    busy && cmdWr && !fiWr && !doneStb |=> busy && !acceptStb); // R5

  AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |=> !abortReq); // R6

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    acceptStb && acceptType != 2'd3 |-> busy); // R2
endmodule

bind cmd_irq_ctrl cmd_irq_chk i_chk (
  .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdData(cmdData),
  .doneStb(doneStb), .busy(busy), .intrq(intrq), .acceptStb(acceptStb),
  .acceptType(acceptType), .abortReq(abortReq)
);

// File: tb/test_cmd_irq_ctrl.sv
module test_cmd_irq_ctrl;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic cmdWr = 0, statRd = 0, doneStb = 0, drvReady = 1, idxPulse = 0, wrProtN = 1;
  logic [7:0] cmdData = 8'h00;
  logic busy, intrq, wpStat, acceptStb, abortReq;
  logic [1:0] acceptType;
  int checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  cmd_irq_ctrl i_cmd_irq_ctrl (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdData(cmdData), .statRd(statRd),
    .doneStb(doneStb), .drvReady(drvReady), .idxPulse(idxPulse), .wrProtN(wrProtN),
    .busy(busy), .intrq(intrq), .wpStat(wpStat), .acceptStb(acceptStb),
    .acceptType(acceptType), .abortReq(abortReq)
  );

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrCmd(logic [7:0] d);
    @(negedge clk); cmdWr = 1; cmdData = d;
    @(negedge clk); cmdWr = 0;
  endtask

  task automatic done();
    @(negedge clk); doneStb = 1;
    @(negedge clk); doneStb = 0;
  endtask

  task automatic rdStat();
    @(negedge clk); statRd = 1;
    @(negedge clk); statRd = 0;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 0;
    idle(2); rstN = 1; idle(4);
  endtask

  task automatic tReset();
    chk("R1", "busy", busy, 0); chk("R1", "intrq", intrq, 0);
    chk("R1", "acceptStb", acceptStb, 0); chk("R1", "abortReq", abortReq, 0);
    chk("R1", "wpStat", wpStat, 0);
  endtask

  task automatic tTypeOne();
    wrCmd(8'h00);
    chk("R2", "strobe", acceptStb, 1); chk("R2", "type", acceptType, 0);
    chk("R2", "busy", busy, 1);
    idle(1); chk("R2", "strobe one cycle", acceptStb, 0);
    done(); chk("R3", "busy after done", busy, 0); chk("R3", "intrq", intrq, 1);
    rdStat(); chk("R4", "intrq after read", intrq, 0);
    done(); chk("R3", "idle done intrq", intrq, 0); chk("R3", "idle done busy", busy, 0);
  endtask

  task automatic tDecode();
    logic [7:0] cmds [5] = '{8'h80, 8'hA0, 8'hC0, 8'hE0, 8'hF0};
    logic [1:0] exps [5] = '{2'd1, 2'd1, 2'd2, 2'd2, 2'd2};
    for (int i = 0; i < 5; i++) begin
      wrCmd(cmds[i]);
      chk("R2", "class strobe", acceptStb, 1); chk("R2", "class code", acceptType, exps[i]);
      done(); rdStat();
    end
  endtask

  task automatic tBusyIgnore();
    wrCmd(8'h10);
    wrCmd(8'h80);
    chk("R5", "no strobe", acceptStb, 0); chk("R5", "still busy", busy, 1);
    chk("R5", "intrq unchanged", intrq, 0);
    done(); rdStat();
  endtask

  task automatic tPriority();
    wrCmd(8'h00);
    @(negedge clk); doneStb = 1; statRd = 1;
    @(negedge clk); doneStb = 0; statRd = 0;
    chk("R4", "set wins over read", intrq, 1);
    wrCmd(8'h00);
    chk("R4", "write clears intrq", intrq, 0); chk("R4", "busy", busy, 1);
    done(); rdStat();
  endtask

  task automatic tForceAbort();
    wrCmd(8'h00);
    wrCmd(8'hD0);
    chk("R6", "busy cleared", busy, 0); chk("R6", "abortReq", abortReq, 1);
    chk("R6", "strobe", acceptStb, 1); chk("R6", "code", acceptType, 3);
    chk("R6", "no intrq", intrq, 0);
    idle(1); chk("R6", "abort one cycle", abortReq, 0);
    idle(3); chk("R6", "still no intrq", intrq, 0);
  endtask

  task automatic tReadyEdges();
    wrCmd(8'hD1);
    chk("R6", "idle fi no abort", abortReq, 0);
    drvReady = 0; idle(5); chk("R7", "unarmed fall", intrq, 0);
    drvReady = 1; idle(5); chk("R7", "armed rise", intrq, 1);
    rdStat();
    wrCmd(8'hD2);
    drvReady = 0; idle(5); chk("R7", "armed fall", intrq, 1);
    rdStat(); drvReady = 1; idle(5); rdStat();
  endtask

  task automatic tIndex();
    wrCmd(8'hD4);
    idxPulse = 1; idle(2); idxPulse = 0; idle(4);
    chk("R8", "index armed", intrq, 1);
    rdStat();
    wrCmd(8'h00); done(); rdStat();
    idxPulse = 1; idle(2); idxPulse = 0; idle(4);
    chk("R8", "disarmed by command", intrq, 0);
  endtask

  task automatic tNotReady();
    drvReady = 0; idle(4);
    wrCmd(8'h80);
    chk("R10", "busy", busy, 0); chk("R10", "no strobe", acceptStb, 0);
    chk("R10", "intrq", intrq, 1);
    wrCmd(8'h00);
    chk("R10", "class I runs", busy, 1); chk("R10", "class I strobe", acceptStb, 1);
    done(); rdStat();
    drvReady = 1; idle(4);
  endtask

  task automatic tWrProt();
    wrProtN = 0;
    wrCmd(8'hA0);
    chk("R11", "busy", busy, 0); chk("R11", "intrq", intrq, 1);
    chk("R11", "wpStat", wpStat, 1); chk("R11", "no strobe", acceptStb, 0);
    wrCmd(8'hF0);
    chk("R11", "track write refused", busy, 0); chk("R11", "wp held", wpStat, 1);
    wrCmd(8'h80);
    chk("R11", "read runs", busy, 1); chk("R11", "wp cleared", wpStat, 0);
    done(); rdStat(); wrProtN = 1;
  endtask

  task automatic tImmediate();
    wrCmd(8'hD8);
    chk("R9", "immediate", intrq, 1);
    rdStat(); chk("R9", "held over read", intrq, 1);
    wrCmd(8'h00); chk("R9", "held over command", intrq, 1);
    done();
    doReset(); chk("R9", "cleared by reset", intrq, 0);
  endtask

  initial begin
    idle(3); rstN = 1; idle(4);
    tReset(); tTypeOne(); tDecode(); tBusyIgnore(); tPriority(); tForceAbort();
    tReadyEdges(); tIndex(); tNotReady(); tWrProt(); tImmediate();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule